// File: doc/BRIEF.md
# Row/Column Matrix Store

This block stores a square matrix of fixed-width elements: 16 by 16 entries of 32 bits each by default. It returns a whole row or a whole column as one wide word in a single read. Writes arrive one element per cycle, addressed by a row index and a column index. A read names an orientation and an index. One registered cycle later, the block presents all elements of that row or column side by side on a 512-bit output, together with a valid strobe.

Inside, the block keeps two copies of the matrix, and every write goes to both. The row copy is split into one small memory per column. The column copy is split into one small memory per row. Either kind of read is then a single address applied in parallel to every memory of one copy. Each memory uses a plain write-synchronous, read-combinational style, so synthesis can place it in small distributed RAM rather than in flip-flops.

Top module: `matrix_store`

## Requirements
- R1: While `rst_ni` is low, and after reset until the first read, `rd_valid_o` is 0.
- R2: With `rd_orient_i` = 0 (row), output lane k (bits 32k+31 down to 32k of `rd_data_o`) carries the element at row `rd_idx_i`, column k.
- R3: With `rd_orient_i` = 1 (column), output lane k carries the element at row k, column `rd_idx_i`.
- R4: One write with `wr_en_i` = 1 stores `wr_data_i` at (`wr_row_i`, `wr_col_i`). The element is then visible to both row reads and column reads, and exactly one memory in each copy is written.
- R5: `rd_data_o` and `rd_valid_o` update on the clock edge that samples `rd_en_i` = 1. `rd_valid_o` falls on the edge after `rd_en_i` is sampled as 0.
- R6: A read and a write to the same element in the same cycle return the value held before the write.
- R7: While `rd_en_i` is 0, `rd_data_o` keeps its last value, whatever the orientation and index inputs do.
- R8: With `wr_en_i` = 0, the write index and data inputs change no stored element.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write one element |
| wr_row_i | input | 4 | Row index of the write |
| wr_col_i | input | 4 | Column index of the write |
| wr_data_i | input | 32 | Element value |
| rd_en_i | input | 1 | Read request |
| rd_orient_i | input | 1 | 0 = row, 1 = column |
| rd_idx_i | input | 4 | Row or column index |
| rd_data_o | output | 512 | Selected row or column, lane k at bits 32k+31:32k |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |

## Verification
Every read result, and the valid strobe, is due exactly one clock edge after the request is sampled. A write becomes visible to any read sampled on a later edge, and is not visible to a read sampled on the same edge. The bench drives each stimulus at a falling edge and computes the expected word from its model before it applies that cycle's write. It compares the outputs at the next falling edge, so each check sits one register stage after its stimulus and away from the capturing edge. Cycles with no read check that the output word still holds its previous value.

// File: rtl/mstore_pkg.sv
package mstore_pkg;
  localparam int unsigned DIM_DEF  = 16;
  localparam int unsigned ELEM_DEF = 32;

  typedef enum logic {
    ORIENT_ROW = 1'b0,
    ORIENT_COL = 1'b1
  } orient_e;
endpackage

// File: rtl/mstore_bank.sv
// One small RAM: synchronous write, combinational read (distributed-RAM style)
module mstore_bank #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/mstore_copy.sv
// One full copy of the matrix: N banks, bank_sel picks the bank to write,
// all banks are read at the same address.
module mstore_copy #(
  parameter int unsigned N  = 16,
  parameter int unsigned W  = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           wr_en_i,
  input  logic [IW-1:0]  wr_bank_i,
  input  logic [IW-1:0]  wr_addr_i,
  input  logic [W-1:0]   wr_data_i,
  input  logic [IW-1:0]  rd_addr_i,
  output logic [N*W-1:0] rd_word_o,
  output logic [N-1:0]   bank_we_o
);
  for (genvar k = 0; k < N; k++) begin : g_bank
    assign bank_we_o[k] = wr_en_i && (wr_bank_i == IW'(k));

    mstore_bank #(
      .DEPTH (N),
      .WIDTH (W)
    ) u_bank (
      .clk_i   (clk_i),
      .we_i    (bank_we_o[k]),
      .waddr_i (wr_addr_i),
      .wdata_i (wr_data_i),
      .raddr_i (rd_addr_i),
      .rdata_o (rd_word_o[k*W +: W])
    );
  end
endmodule

// File: rtl/matrix_store.sv
module matrix_store
  import mstore_pkg::*;
#(
  parameter int unsigned N  = DIM_DEF,
  parameter int unsigned W  = ELEM_DEF,
  localparam int unsigned IW = $clog2(N),
  localparam int unsigned OW = N * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_row_i,
  input  logic [IW-1:0] wr_col_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_en_i,
  input  logic          rd_orient_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [OW-1:0] rd_data_o,
  output logic          rd_valid_o
);
  logic [OW-1:0] row_word, col_word;
  logic [N-1:0]  row_we, col_we;
  orient_e       orient;

  assign orient = orient_e'(rd_orient_i);

  // row copy: bank = column, address = row
  mstore_copy #(.N(N), .W(W)) u_row_copy (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_bank_i (wr_col_i),
    .wr_addr_i (wr_row_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_idx_i),
    .rd_word_o (row_word),
    .bank_we_o (row_we)
  );

  // column copy: bank = row, address = column
  mstore_copy #(.N(N), .W(W)) u_col_copy (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en_i),
    .wr_bank_i (wr_row_i),
    .wr_addr_i (wr_col_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_idx_i),
    .rd_word_o (col_word),
    .bank_we_o (col_we)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_valid_o <= 1'b0;
    else         rd_valid_o <= rd_en_i;
  end

  // data register not reset; contents are undefined until written
  always_ff @(posedge clk_i) begin
    if (rd_en_i) rd_data_o <= (orient == ORIENT_COL) ? col_word : row_word;
  end
endmodule

// File: rtl/mstore_chk.sv
module mstore_chk #(
  parameter int unsigned N  = 16,
  parameter int unsigned OW = 512
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          rd_valid_o,
  input logic [OW-1:0] rd_data_o,
  input logic [N-1:0]  row_we,
  input logic [N-1:0]  col_we
);
  logic seen_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      seen_rd_q <= 1'b0;
    else if (rd_en_i) seen_rd_q <= 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_no_valid_in_reset: assert (!rd_valid_o)
        else $error("rd_valid_o high in reset");
    end
  end

  a_r5_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);

  a_r5_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);

  a_r7_data_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_en_i && seen_rd_q) |=> $stable(rd_data_o));

  a_r4_one_bank_per_copy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ($countones(row_we) == 1 && $countones(col_we) == 1));

  a_r8_no_bank_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |-> (row_we == '0 && col_we == '0));
endmodule

bind matrix_store mstore_chk #(.N(N), .OW(OW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .row_we     (row_we),
  .col_we     (col_we)
);

// File: tb/matrix_store_tb.sv
`timescale 1ns/1ps
module matrix_store_tb;
  localparam int N = 16;
  localparam int W = 32;
  localparam int OW = N * W;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          wr_en;
  logic [3:0]    wr_row, wr_col;
  logic [W-1:0]  wr_data;
  logic          rd_en, rd_orient;
  logic [3:0]    rd_idx;
  logic [OW-1:0] rd_data;
  logic          rd_valid;

  always #(CLK_PERIOD/2) clk = ~clk;

  matrix_store u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en), .wr_row_i(wr_row), .wr_col_i(wr_col), .wr_data_i(wr_data),
    .rd_en_i(rd_en), .rd_orient_i(rd_orient), .rd_idx_i(rd_idx),
    .rd_data_o(rd_data), .rd_valid_o(rd_valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0]  model [N][N];
  logic [OW-1:0] exp_data;
  logic          exp_valid;
  logic          data_known;
  logic          pend;
  string         exp_tag;

  function automatic logic [OW-1:0] model_read(logic ori, logic [3:0] idx);
    logic [OW-1:0] w;
    for (int k = 0; k < N; k++)
      w[k*W +: W] = ori ? model[k][idx] : model[idx][k];
    return w;
  endfunction

  task automatic check_now();
    n_chk++;
    if (rd_valid !== exp_valid) begin
      n_bad++;
      $display("FAIL %s valid: actual %b expected %b", exp_tag, rd_valid, exp_valid);
    end
    if (data_known) begin
      n_chk++;
      if (rd_data !== exp_data) begin
        n_bad++;
        $display("FAIL %s data: actual %h expected %h", exp_tag, rd_data, exp_data);
      end
    end
  endtask

  // one cycle: check result of previous cycle, then drive new stimulus
  task automatic step(input logic we, input logic [3:0] r, input logic [3:0] c,
                      input logic [W-1:0] d, input logic re, input logic ori,
                      input logic [3:0] idx, input string tag);
    @(negedge clk);
    if (pend) check_now();
    wr_en = we; wr_row = r; wr_col = c; wr_data = d;
    rd_en = re; rd_orient = ori; rd_idx = idx;
    exp_valid = re;
    if (re) begin
      exp_data   = model_read(ori, idx);   // old contents: read-before-write
      data_known = 1'b1;
      exp_tag    = tag;
    end else begin
      exp_tag    = (tag == "") ? "R7" : tag;
    end
    if (we) model[r][c] = d;
    pend = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    pend = 1'b0; data_known = 1'b0; exp_valid = 1'b0; exp_data = '0; exp_tag = "";
    rst_ni = 1'b0;
    wr_en = 0; wr_row = 0; wr_col = 0; wr_data = 0; rd_en = 0; rd_orient = 0; rd_idx = 0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (rd_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1 in reset: actual %b expected 0", rd_valid);
    end
    rst_ni = 1'b1;
    @(negedge clk);
    n_chk++;
    if (rd_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1 after reset: actual %b expected 0", rd_valid);
    end

    // fill every element (R4)
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++)
        step(1'b1, 4'(r), 4'(c), {4'(r), 4'(c), 24'(r*N + c) ^ 24'hA5A5A5}, 1'b0, 1'b0, 4'd0, "R1");

    // directed: all rows, then all columns
    for (int i = 0; i < N; i++) step(1'b0, 0, 0, 0, 1'b1, 1'b0, 4'(i), "R2");
    for (int i = 0; i < N; i++) step(1'b0, 0, 0, 0, 1'b1, 1'b1, 4'(i), "R3");

    // R4: one write seen by row and by column read
    step(1'b1, 4'd7, 4'd2, 32'hDEAD_BEEF, 1'b0, 1'b0, 4'd0, "R4");
    step(1'b0, 0, 0, 0, 1'b1, 1'b0, 4'd7, "R4");
    step(1'b0, 0, 0, 0, 1'b1, 1'b1, 4'd2, "R4");

    // R6: same-cycle read and write of one element, both orientations
    step(1'b1, 4'd3, 4'd5, 32'h1111_2222, 1'b1, 1'b0, 4'd3, "R6");
    step(1'b1, 4'd3, 4'd5, 32'h3333_4444, 1'b1, 1'b1, 4'd5, "R6");
    step(1'b0, 0, 0, 0, 1'b1, 1'b0, 4'd3, "R6");

    // R8: disabled write with busy inputs, then read back
    step(1'b0, 4'd0, 4'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 4'd0, "R8");
    step(1'b0, 4'd15, 4'd15, 32'h0BAD_F00D, 1'b0, 1'b1, 4'd9, "R8");
    step(1'b0, 0, 0, 0, 1'b1, 1'b0, 4'd0, "R8");
    step(1'b0, 0, 0, 0, 1'b1, 1'b0, 4'd15, "R8");

    // R5/R7: idle cycles with changing orientation and index
    step(1'b0, 0, 0, 0, 1'b0, 1'b1, 4'd4, "R5");
    step(1'b0, 0, 0, 0, 1'b0, 1'b0, 4'd11, "R7");
    step(1'b0, 0, 0, 0, 1'b1, 1'b1, 4'd15, "R5");

    // constrained random mix
    for (int t = 0; t < 3000; t++) begin
      logic we, re, ori;
      logic [3:0] r, c, idx;
      logic [W-1:0] d;
      we = ($urandom % 100) < 60;
      re = ($urandom % 100) < 55;
      ori = $urandom % 2;
      r = 4'($urandom); c = 4'($urandom); d = $urandom;
      idx = (($urandom % 4) == 0) ? (ori ? c : r) : 4'($urandom);
      step(we, r, c, d, re, ori, idx, re ? (ori ? "R3" : "R2") : "R7");
    end

    step(1'b0, 0, 0, 0, 1'b0, 1'b0, 4'd0, "R5");
    @(negedge clk);
    check_now();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule